// File: doc/BRIEF.md
# Two-Sided Hardware Lock with Queued Claim

This block guards one shared resource between two agents, called the left side and the right side. Each side owns a write strobe with one data bit and a status output. Writing 0 is a claim on the lock. Writing 1 gives it back. The status reads 0 while that side holds the lock and 1 while it does not.

A claim that loses to the current holder is not dropped. It is remembered as a waiting claim. When the holder gives the lock back, the lock moves straight to the waiting side, so the loser does not have to poll and retry. A waiting side can cancel its claim by writing 1.

When both sides claim a free lock in the same cycle, a parameter decides which side wins. The other side's claim becomes a waiting claim. A second parameter can build a plain test-and-set variant instead, in which losing claims are forgotten.

Top module: `sema_dual`

## Requirements
- R1: After reset the lock is free, both status outputs read 1, and no claim is waiting, so a later take-and-give-back by one side leaves both statuses at 1.
- R2: A write of 0 by one side while the lock is free gives that side the lock: its status reads 0 and the other side's reads 1.
- R3: A write of 0 by one side while the other side holds the lock changes no status: the claimant keeps reading 1 and the holder keeps reading 0.
- R4: When the holder writes 1 while the other side has a waiting claim, including a claim written in that same cycle, the other side's status becomes 0 and the former holder's becomes 1.
- R5: When the holder writes 1 and the other side has no waiting claim, both statuses become 1.
- R6: A write of 1 by the side that does not hold the lock leaves the holder's status at 0.
- R7: A side with a waiting claim that writes 1 cancels that claim, so the holder's later write of 1 leaves both statuses at 1.
- R8: With the default tie setting (left wins), a write of 0 by both sides on a free lock in the same cycle makes the left status 0 and the right status 1. The right claim waits and is granted when the left side writes 1.
- R9: A status output changes only on the clock edge that follows a write, and it holds its value in any cycle with no write.
- R10: The two status outputs never both read 0.
- R11: A write of 0 by the side that already holds the lock changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lft_we | input | 1 | Left side write strobe |
| lft_wd | input | 1 | Left side write data (0 = claim, 1 = give back) |
| lft_stat | output | 1 | Left side status (0 = left holds the lock) |
| rgt_we | input | 1 | Right side write strobe |
| rgt_wd | input | 1 | Right side write data (0 = claim, 1 = give back) |
| rgt_stat | output | 1 | Right side status (0 = right holds the lock) |

## Verification
Directed sequences cover several cases:
- single claims on a free lock, which separate a grant from a wrong owner;
- claims against a holder, which separate a queued claim from a wrongly taken lock;
- a give-back with and without a waiting claim, which separate a hand-over from a release;
- a cancelled claim, which separates cancel from grant;
- simultaneous claims, which test the tie rule.

A same-cycle claim by one side and give-back by the other checks that the hand-over still happens in that case. A mid-run reset that lands while a claim is waiting shows that reset clears waiting claims. Long stretches of random writes on both sides are compared every cycle with a behavioural model.

// File: rtl/sema_pkg.sv
package sema_pkg;
   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } sema_owner_t;

   typedef struct packed {
      logic take;
      logic give;
   } sema_cmd_t;

   localparam int unsigned SIDES = 2;
endpackage

// File: rtl/sema_port.sv
module sema_port
   import sema_pkg::*;
#(
   parameter int unsigned SIDE = 0
) (
   input  logic        wr_en,
   input  logic        wr_bit,
   input  sema_owner_t owner,
   output sema_cmd_t   cmd,
   output logic        status
);
   localparam sema_owner_t MINE = (SIDE == 0) ? OWN_LEFT : OWN_RIGHT;

   generate
      if (SIDE > 1) begin : g_bad_side
         $error("sema_port: SIDE must be 0 or 1");
      end
   endgenerate

   always_comb begin
      cmd.take = wr_en & ~wr_bit;
      cmd.give = wr_en &  wr_bit;
      status   = (owner != MINE);
   end
endmodule

// File: rtl/sema_core.sv
module sema_core
   import sema_pkg::*;
#(
   parameter bit TIE_LEFT = 1'b1,
   parameter bit QUEUE_EN = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  sema_cmd_t   cmd [SIDES],
   output sema_owner_t owner,
   output logic [SIDES-1:0] waiting
);
   localparam int unsigned WIN  = TIE_LEFT ? 0 : 1;
   localparam int unsigned LOSE = 1 - WIN;

   sema_owner_t owner_q, owner_d;
   logic [SIDES-1:0] wait_q, wait_d, wait_upd;
   sema_owner_t side_own [SIDES];

   assign side_own[0] = OWN_LEFT;
   assign side_own[1] = OWN_RIGHT;

   // A claim or cancel written this cycle updates the waiting flag first.
   generate
      for (genvar s = 0; s < SIDES; s++) begin : g_wait
         if (QUEUE_EN) begin : g_queue
            assign wait_upd[s] = cmd[s].take ? 1'b1 :
                                 cmd[s].give ? 1'b0 : wait_q[s];
         end else begin : g_plain
            assign wait_upd[s] = 1'b0;
         end
      end
   endgenerate

   always_comb begin
      owner_d = owner_q;
      wait_d  = '0;
      unique case (owner_q)
         OWN_NONE: begin
            if (cmd[0].take && cmd[1].take) begin
               owner_d        = side_own[WIN];
               wait_d[LOSE]   = QUEUE_EN;
            end else if (cmd[0].take) begin
               owner_d = OWN_LEFT;
            end else if (cmd[1].take) begin
               owner_d = OWN_RIGHT;
            end
         end
         OWN_LEFT: begin
            wait_d[1] = wait_upd[1];
            if (cmd[0].give) begin
               owner_d   = wait_upd[1] ? OWN_RIGHT : OWN_NONE;
               wait_d[1] = 1'b0;
            end
         end
         OWN_RIGHT: begin
            wait_d[0] = wait_upd[0];
            if (cmd[1].give) begin
               owner_d   = wait_upd[0] ? OWN_LEFT : OWN_NONE;
               wait_d[0] = 1'b0;
            end
         end
         default: begin
            owner_d = OWN_NONE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owner_q <= OWN_NONE;
         wait_q  <= '0;
      end else begin
         owner_q <= owner_d;
         wait_q  <= wait_d;
      end
   end

   assign owner   = owner_q;
   assign waiting = wait_q;
endmodule

// File: rtl/sema_dual.sv
module sema_dual
   import sema_pkg::*;
#(
   parameter bit TIE_LEFT = 1'b1,
   parameter bit QUEUE_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lft_we,
   input  logic lft_wd,
   output logic lft_stat,
   input  logic rgt_we,
   input  logic rgt_wd,
   output logic rgt_stat
);
   sema_cmd_t        cmd  [SIDES];
   logic [SIDES-1:0] we_v, wd_v, st_v;
   logic [SIDES-1:0] waiting;
   sema_owner_t      owner;

   assign we_v = {rgt_we, lft_we};
   assign wd_v = {rgt_wd, lft_wd};

   generate
      for (genvar s = 0; s < SIDES; s++) begin : g_side
         sema_port #(.SIDE(s)) u_port (
            .wr_en  (we_v[s]),
            .wr_bit (wd_v[s]),
            .owner  (owner),
            .cmd    (cmd[s]),
            .status (st_v[s])
         );
      end
   endgenerate

   sema_core #(.TIE_LEFT(TIE_LEFT), .QUEUE_EN(QUEUE_EN)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd     (cmd),
      .owner   (owner),
      .waiting (waiting)
   );

   assign lft_stat = st_v[0];
   assign rgt_stat = st_v[1];
endmodule

// File: rtl/sema_dual_chk.sv
module sema_dual_chk #(
   parameter bit TIE_LEFT = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic lft_we,
   input logic lft_wd,
   input logic lft_stat,
   input logic rgt_we,
   input logic rgt_wd,
   input logic rgt_stat
);
   logic l_take, r_take, l_give, r_give;
   assign l_take = lft_we & ~lft_wd;
   assign r_take = rgt_we & ~rgt_wd;
   assign l_give = lft_we &  lft_wd;
   assign r_give = rgt_we &  rgt_wd;

   p_mutex_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(!lft_stat && !rgt_stat));

   p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!lft_we && !rgt_we) |=> ($stable(lft_stat) && $stable(rgt_stat)));

   p_grant_left_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (lft_stat && rgt_stat && l_take && !r_take) |=> (!lft_stat && rgt_stat));

   p_grant_right_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (lft_stat && rgt_stat && r_take && !l_take) |=> (lft_stat && !rgt_stat));

   p_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!rgt_stat && l_take && !r_give) |=> (lft_stat && !rgt_stat));

   p_give_frees_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!lft_stat && l_give) |=> lft_stat);

   p_outsider_give_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!lft_stat && r_give && !l_give) |=> !lft_stat);

   generate
      if (TIE_LEFT) begin : g_tie_l
         p_tie_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (lft_stat && rgt_stat && l_take && r_take) |=> (!lft_stat && rgt_stat));
      end else begin : g_tie_r
         p_tie_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (lft_stat && rgt_stat && l_take && r_take) |=> (lft_stat && !rgt_stat));
      end
   endgenerate
endmodule

bind sema_dual sema_dual_chk #(.TIE_LEFT(TIE_LEFT)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .lft_we   (lft_we),
   .lft_wd   (lft_wd),
   .lft_stat (lft_stat),
   .rgt_we   (rgt_we),
   .rgt_wd   (rgt_wd),
   .rgt_stat (rgt_stat)
);

// File: tb/sim_sema_dual.sv
module sim_sema_dual;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lft_we = 1'b0, lft_wd = 1'b1, rgt_we = 1'b0, rgt_wd = 1'b1;
   logic lft_stat, rgt_stat;

   int total = 0;
   int bad   = 0;
   int cycles = 0;

   // behavioural reference: holder 0 none, 1 left, 2 right
   int m_hold = 0;
   bit m_wl = 0, m_wr = 0;

   always #5 clk = ~clk;

   sema_dual u0 (
      .clk(clk), .rst_n(rst_n),
      .lft_we(lft_we), .lft_wd(lft_wd), .lft_stat(lft_stat),
      .rgt_we(rgt_we), .rgt_wd(rgt_wd), .rgt_stat(rgt_stat)
   );

   always @(posedge clk) begin
      bit lt, lg, rt, rg;
      lt = lft_we && !lft_wd; lg = lft_we && lft_wd;
      rt = rgt_we && !rgt_wd; rg = rgt_we && rgt_wd;
      if (!rst_n) begin
         m_hold = 0; m_wl = 0; m_wr = 0;
      end else if (m_hold == 0) begin
         if (lt) begin m_hold = 1; m_wr = rt; end
         else if (rt) m_hold = 2;
      end else if (m_hold == 1) begin
         if (rt) m_wr = 1; else if (rg) m_wr = 0;
         if (lg) begin m_hold = m_wr ? 2 : 0; m_wr = 0; end
      end else begin
         if (lt) m_wl = 1; else if (lg) m_wl = 0;
         if (rg) begin m_hold = m_wl ? 1 : 0; m_wl = 0; end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         total++;
         if (lft_stat !== (m_hold != 1) || rgt_stat !== (m_hold != 2)) begin
            bad++;
            $display("FAIL R9 model compare: got l=%b r=%b expected l=%b r=%b",
                     lft_stat, rgt_stat, m_hold != 1, m_hold != 2);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         bad++;
         $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic check(input logic el, input logic er, input string tag);
      total++;
      if (lft_stat !== el || rgt_stat !== er) begin
         bad++;
         $display("FAIL %s: got l=%b r=%b expected l=%b r=%b", tag, lft_stat, rgt_stat, el, er);
      end
   endtask

   // one write cycle, then inputs idle; status sampled after the update edge
   task automatic step(input logic lw, input logic ld, input logic rw, input logic rd,
                       input logic el, input logic er, input string tag);
      @(negedge clk);
      lft_we = lw; lft_wd = ld; rgt_we = rw; rgt_wd = rd;
      @(negedge clk);
      lft_we = 1'b0; rgt_we = 1'b0;
      check(el, er, tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(1, 1, "R1 reset free");
      step(1,0, 0,0, 0,1, "R2 left takes free lock");
      step(0,0, 1,0, 0,1, "R3 right claim blocked");
      step(1,0, 0,0, 0,1, "R11 holder rewrites 0");
      step(1,1, 0,0, 1,0, "R4 hand-over to waiting right");
      step(1,1, 0,0, 1,0, "R6 outsider give ignored");
      step(0,0, 1,1, 1,1, "R5 give with no waiter frees");
      step(0,0, 1,0, 1,0, "R2 right takes free lock");
      step(1,0, 0,0, 1,0, "R3 left claim blocked");
      step(1,1, 0,0, 1,0, "R7 left cancels claim");
      step(0,0, 1,1, 1,1, "R7 cancelled claim not granted");
      repeat (4) @(negedge clk);
      check(1, 1, "R9 idle holds state");
      step(1,0, 1,0, 0,1, "R8 tie left wins");
      step(1,1, 0,0, 1,0, "R8 right waiter granted");
      step(0,0, 1,1, 1,1, "R5 right gives back");
      step(0,0, 1,0, 1,0, "R2 right takes again");
      step(1,0, 1,1, 0,1, "R4 same-cycle claim and give");
      repeat (3) @(negedge clk);
      check(0, 1, "R9 idle keeps holder");
      step(0,0, 1,0, 0,1, "R3 right waits");
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      check(1, 1, "R1 reset mid-run");
      step(1,0, 0,0, 0,1, "R1 left takes after reset");
      step(1,1, 0,0, 1,1, "R1 no waiter survives reset");
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         lft_we = $urandom_range(0, 1); lft_wd = $urandom_range(0, 1);
         rgt_we = $urandom_range(0, 1); rgt_wd = $urandom_range(0, 1);
         if (lft_stat == 1'b0 && rgt_stat == 1'b0) begin
            bad++;
            $display("FAIL R10: got both statuses 0 expected at most one");
         end
         total++;
      end
      @(negedge clk);
      lft_we = 1'b0; rgt_we = 1'b0;
      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule